// File: doc/BRIEF.md
# Lane-Forwarding Synchronous RAM

This block is a synchronous memory with one write port and one clocked read port on a single clock. The storage array it holds returns the old contents when a read and a write hit the same address in the same cycle. The block adds forwarding logic so that the read port behaves as write-through. After such a collision, each byte-style lane that the write enabled shows the newly written value, and each lane that the write left alone shows the stored value.

A word is split into `EN_BITS` lanes of `DBITS / EN_BITS` bits each. Each lane has its own write-enable bit. The forwarding is done per lane, so a partial write that collides with a read yields a merged word.

Both ports are plain synchronous memory ports rather than streams. A read is accepted on every clock edge where `rd_en` is high, and its data appears one cycle later. A write is accepted on every edge where any `wr_en` bit is set. The ports have no back-pressure: neither side can stall the other.

Top module: `lane_bypass_ram`

## Requirements
- R1: While `rst_n` is low, and after its release until the first enabled read completes, `rd_data` is all zeros.
- R2: When `rd_en` is high and the read address differs from the write address, or no write lane is enabled, `rd_data` shows the word stored at `rd_addr` on the clock edge after the request.
- R3: A write updates only the lanes whose `wr_en` bit is 1. All other lanes at that address keep their earlier contents.
- R4: When `rd_en` is high and `rd_addr` equals `wr_addr` in the same cycle, every lane whose `wr_en` bit is set shows that cycle's `wr_data` lane in `rd_data` one cycle later.
- R5: In such a same-address cycle, every lane whose `wr_en` bit is clear shows the value stored before the write.
- R6: While `rd_en` is low, `rd_data` holds its previous value, even when writes land on the address last read.
- R7: A word written on one edge is returned by any later read of that address that is not itself overlapped by another write to it.
- R8: Lane i occupies bits [i*W +: W], where W = DBITS/EN_BITS, and is governed by bit i of `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read-side registers |
| wr_en | input | EN_BITS | Per-lane write enable |
| wr_addr | input | ABITS | Write word address |
| wr_data | input | DBITS | Write data |
| rd_en | input | 1 | Read request; when low, the output holds |
| rd_addr | input | ABITS | Read word address |
| rd_data | output | DBITS | Read data, valid one cycle after a request |

## Verification
The bench uses the default build: a 16-word array of 32-bit words, split into four 8-bit lanes. With only sixteen words, random addresses collide often. The bench forces half of the reads onto the write address, so every subset of the four lane enables shows up in collision cycles. The bench seeds the whole array first. Directed cases then cover a full-lane collision, a single-lane collision at the top address, and a collision while reads are held.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  function automatic int unsigned lane_width(input int unsigned dbits, input int unsigned lanes);
    return dbits / lanes;
  endfunction
endpackage

// File: rtl/lbr_array.sv
module lbr_array
  import lbr_pkg::*;
#(
  parameter int unsigned ABITS   = 4,
  parameter int unsigned DBITS   = 32,
  parameter int unsigned EN_BITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EN_BITS-1:0] wr_en,
  input  logic [ABITS-1:0]   wr_addr,
  input  logic [DBITS-1:0]   wr_data,
  input  logic               rd_en,
  input  logic [ABITS-1:0]   rd_addr,
  output logic [DBITS-1:0]   rd_q
);
  localparam int unsigned LW    = lane_width(DBITS, EN_BITS);
  localparam int unsigned DEPTH = 1 << ABITS;

  logic [DBITS-1:0] store [DEPTH];

  // lane-masked write
  always_ff @(posedge clk) begin
    for (int l = 0; l < EN_BITS; l++) begin
      if (wr_en[l]) store[wr_addr][l*LW +: LW] <= wr_data[l*LW +: LW];
    end
  end

  // registered read returning pre-write contents
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= store[rd_addr];
  end

  AST_ARRAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q)); // R6
endmodule

// File: rtl/lbr_hit_track.sv
module lbr_hit_track #(
  parameter int unsigned ABITS   = 4,
  parameter int unsigned DBITS   = 32,
  parameter int unsigned EN_BITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EN_BITS-1:0] wr_en,
  input  logic [ABITS-1:0]   wr_addr,
  input  logic [DBITS-1:0]   wr_data,
  input  logic               rd_en,
  input  logic [ABITS-1:0]   rd_addr,
  output logic [EN_BITS-1:0] hit_q,
  output logic [DBITS-1:0]   wdata_q
);
  logic [EN_BITS-1:0] hit_d;

  always_comb hit_d = (wr_addr == rd_addr) ? wr_en : '0;

  // flags and captured data advance together with the read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= '0;
      wdata_q <= '0;
    end else if (rd_en) begin
      hit_q   <= hit_d;
      wdata_q <= wr_data;
    end
  end

  AST_HIT_CLEAR_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (wr_addr != rd_addr)) |=> (hit_q == '0)); // R2
endmodule

// File: rtl/lbr_lane_mux.sv
module lbr_lane_mux
  import lbr_pkg::*;
#(
  parameter int unsigned DBITS   = 32,
  parameter int unsigned EN_BITS = 4
) (
  input  logic [EN_BITS-1:0] hit_q,
  input  logic [DBITS-1:0]   wdata_q,
  input  logic [DBITS-1:0]   ram_q,
  output logic [DBITS-1:0]   dout
);
  localparam int unsigned LW = lane_width(DBITS, EN_BITS);

  for (genvar l = 0; l < EN_BITS; l++) begin : g_lane
    assign dout[l*LW +: LW] = hit_q[l] ? wdata_q[l*LW +: LW] : ram_q[l*LW +: LW];
  end
endmodule

// File: rtl/lane_bypass_ram.sv
module lane_bypass_ram
  import lbr_pkg::*;
#(
  parameter int unsigned ABITS   = 4,
  parameter int unsigned DBITS   = 32,
  parameter int unsigned EN_BITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EN_BITS-1:0] wr_en,
  input  logic [ABITS-1:0]   wr_addr,
  input  logic [DBITS-1:0]   wr_data,
  input  logic               rd_en,
  input  logic [ABITS-1:0]   rd_addr,
  output logic [DBITS-1:0]   rd_data
);
  localparam int unsigned LW = lane_width(DBITS, EN_BITS);

  if (DBITS % EN_BITS != 0) begin : g_bad_split
    $error("DBITS must be a multiple of EN_BITS");
  end

  logic [DBITS-1:0]   ram_q;
  logic [DBITS-1:0]   wdata_q;
  logic [EN_BITS-1:0] hit_q;

  lbr_array #(.ABITS(ABITS), .DBITS(DBITS), .EN_BITS(EN_BITS)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_q(ram_q)
  );

  lbr_hit_track #(.ABITS(ABITS), .DBITS(DBITS), .EN_BITS(EN_BITS)) u_hit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .hit_q(hit_q), .wdata_q(wdata_q)
  );

  lbr_lane_mux #(.DBITS(DBITS), .EN_BITS(EN_BITS)) u_mux (
    .hit_q(hit_q), .wdata_q(wdata_q), .ram_q(ram_q), .dout(rd_data)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R6

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data == '0)); // R1

  for (genvar l = 0; l < EN_BITS; l++) begin : g_chk
    AST_LANE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && wr_en[l] && (wr_addr == rd_addr))
        |=> (rd_data[l*LW +: LW] == $past(wr_data[l*LW +: LW]))); // R4
    AST_LANE_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !(wr_en[l] && (wr_addr == rd_addr)))
        |=> (rd_data[l*LW +: LW] == ram_q[l*LW +: LW])); // R5
  end
endmodule

// File: tb/lane_bypass_ram_tb.sv
`timescale 1ns/1ps
module lane_bypass_ram_tb;
  localparam int ABITS = 4;
  localparam int DBITS = 32;
  localparam int EN_BITS = 4;
  localparam int LW = DBITS / EN_BITS;
  localparam int DEPTH = 1 << ABITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [EN_BITS-1:0] wr_en = '0;
  logic [ABITS-1:0] wr_addr = '0;
  logic [DBITS-1:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [ABITS-1:0] rd_addr = '0;
  logic [DBITS-1:0] rd_data;

  logic [DBITS-1:0] ref_mem [DEPTH];
  logic [DBITS-1:0] exp_q;
  string exp_tag;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lane_bypass_ram #(.ABITS(ABITS), .DBITS(DBITS), .EN_BITS(EN_BITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // expected word for a read issued alongside a write
  function automatic logic [DBITS-1:0] predict(input logic [DBITS-1:0] stored,
      input logic [EN_BITS-1:0] we, input logic same, input logic [DBITS-1:0] wd);
    logic [DBITS-1:0] r = stored;
    for (int l = 0; l < EN_BITS; l++)
      if (we[l] && same) r[l*LW +: LW] = wd[l*LW +: LW];
    return r;
  endfunction

  function automatic logic [DBITS-1:0] merge(input logic [DBITS-1:0] old,
      input logic [EN_BITS-1:0] we, input logic [DBITS-1:0] wd);
    logic [DBITS-1:0] r = old;
    for (int l = 0; l < EN_BITS; l++)
      if (we[l]) r[l*LW +: LW] = wd[l*LW +: LW];
    return r;
  endfunction

  task automatic check(input string tag, input logic [DBITS-1:0] exp);
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, exp);
    end
  endtask

  // drive one cycle at the falling edge; check at the next falling edge
  task automatic cyc(input logic [EN_BITS-1:0] we, input logic [ABITS-1:0] wa,
      input logic [DBITS-1:0] wd, input logic re, input logic [ABITS-1:0] ra, input string tag);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    if (re) exp_q = predict(ref_mem[ra], we, (wa == ra), wd);
    ref_mem[wa] = merge(ref_mem[wa], we, wd);
    @(negedge clk);
    check(tag, exp_q);
  endtask

  initial begin
    void'($urandom(32'd4711));
    exp_q = '0;
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", '0);
    // seed array, no reads: output must stay zero
    for (int a = 0; a < DEPTH; a++)
      cyc('1, a[ABITS-1:0], {8'hA0 + 8'(a), 8'hB0 + 8'(a), 8'hC0 + 8'(a), 8'hD0 + 8'(a)}, 1'b0, '0, "R6 R1 seed");
    cyc('0, 4'd0, '0, 1'b1, 4'd5, "R2 plain read");
    cyc(4'b0101, 4'd7, 32'h1122_3344, 1'b1, 4'd2, "R2 read other addr");
    cyc('0, 4'd0, '0, 1'b1, 4'd7, "R3 R7 partial write readback");
    cyc('1, 4'd9, 32'hDEAD_BEEF, 1'b1, 4'd9, "R4 full collision");
    cyc(4'b0110, 4'd3, 32'h5566_7788, 1'b1, 4'd3, "R4 R5 partial collision");
    cyc('0, 4'd0, '0, 1'b1, 4'd3, "R3 R7 after partial collision");
    cyc(4'b1000, 4'd15, 32'hFF00_0000, 1'b1, 4'd15, "R8 top lane at top address");
    cyc('1, 4'd15, 32'h0BAD_CAFE, 1'b0, 4'd15, "R6 hold during write to last read addr");
    cyc('0, 4'd0, '0, 1'b0, 4'd1, "R6 hold second cycle");
    cyc('0, 4'd0, '0, 1'b1, 4'd15, "R7 readback after held write");
    cyc(4'b0001, 4'd0, 32'h0000_0077, 1'b1, 4'd0, "R8 bottom lane collision");
    for (int i = 0; i < 600; i++) begin
      logic [EN_BITS-1:0] we = EN_BITS'($urandom);
      logic [ABITS-1:0] wa = ABITS'($urandom);
      logic re = ($urandom % 4) != 0;
      logic [ABITS-1:0] ra = ($urandom % 2) ? wa : ABITS'($urandom);
      cyc(we, wa, $urandom, re, ra, "R2 R3 R4 R5 R6 random");
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule